// File: doc/BRIEF.md
# Automatic Reseed Scheduler

This block sits beside a random number generator controller. It decides on its own when the generator should draw fresh seed material, without waiting for a command from the host. Two mechanisms run side by side, and either one can trigger a reseed.

The first is a use counter. It is loaded with a programmed count and steps down once for every completed generate operation. The second is an age timer. It is loaded with a programmed period and steps down once for every timer tick. When either one runs out, the block raises a one-cycle reseed request toward the controller. It then waits for the controller to report that a reseed has finished. The controller reports every finished reseed, whether the host started it or this block did. Each report reloads both mechanisms.

Software programs the two reload values through write strobes. A reload value of zero switches its mechanism off.

Top module: `auto_reseed_sched`

## Requirements
- R1: After reset, `reseed_req` is low and both reload values are zero, so neither mechanism can fire until it is programmed.
- R2: With a use reload of N>0, `reseed_req` is high in the cycle that follows the clock edge sampling the N-th `gen_done` counted since the last reload of the use counter.
- R3: With an age reload of N>0, `reseed_req` is high in the cycle that follows the clock edge sampling the N-th `tick` counted since the last reload of the age timer.
- R4: A reload value of zero disables its mechanism: any number of its events produces no request.
- R5: Every `reseed_done` reloads both the counter and the timer from their reload values, whether a request from this block is pending or not. A `gen_done` or `tick` sampled at the same edge as `reseed_done` is not counted.
- R6: A write strobe stores the new value and reloads the matching counter at once. An event of that mechanism sampled at the same edge is discarded.
- R7: Once a request has been issued, no event is counted and no further request is issued until `reseed_done` arrives.
- R8: Each request is exactly one cycle wide. If both mechanisms run out at the same edge, only one request is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_wr | input | 1 | Write strobe for the use-count reload value |
| use_val | input | CNT_W | New use-count reload value |
| age_wr | input | 1 | Write strobe for the age reload value |
| age_val | input | CNT_W | New age reload value |
| gen_done | input | 1 | One-cycle pulse per completed generate operation |
| tick | input | 1 | One-cycle timer tick |
| reseed_done | input | 1 | One-cycle pulse when any reseed finishes |
| reseed_req | output | 1 | One-cycle automatic reseed request |

## Verification
The bench sweeps small reload values for each mechanism and checks the exact event on which the request appears. An off-by-one counter would fire one event early or one event late. It sends extra events while a request is pending, to catch a design that re-arms before `reseed_done`. It also makes both mechanisms run out at the same edge, to catch a doubled pulse or a pulse two cycles wide. Finally, it rewrites a reload value partway through a count and sends a `reseed_done` with no request pending. A design that failed to reload would fire on the stale count.

// File: rtl/auto_reseed_sched.sv
module auto_reseed_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_wr,
  input  logic [CNT_W-1:0] use_val,
  input  logic             age_wr,
  input  logic [CNT_W-1:0] age_val,
  input  logic             gen_done,
  input  logic             tick,
  input  logic             reseed_done,
  output logic             reseed_req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] use_rld, age_rld, use_cnt, age_cnt;
  logic             busy;

  wire use_step = gen_done && !busy && !reseed_done && !use_wr && use_cnt != '0;
  wire age_step = tick     && !busy && !reseed_done && !age_wr && age_cnt != '0;
  wire fire     = (use_step && use_cnt == ONE) || (age_step && age_cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_rld <= '0;
      age_rld <= '0;
    end else begin
      if (use_wr) use_rld <= use_val;
      if (age_wr) age_rld <= age_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           use_cnt <= '0;
    else if (use_wr)      use_cnt <= use_val;
    else if (reseed_done) use_cnt <= use_rld;
    else if (use_step)    use_cnt <= use_cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_cnt <= '0;
    else if (age_wr)      age_cnt <= age_val;
    else if (reseed_done) age_cnt <= age_rld;
    else if (age_step)    age_cnt <= age_cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      reseed_req <= 1'b0;
    end else begin
      reseed_req <= fire;
      if (reseed_done) busy <= 1'b0;
      else if (fire)   busy <= 1'b1;
    end
  end

endmodule

module auto_reseed_sched_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             use_wr,
  input logic [CNT_W-1:0] use_val,
  input logic             gen_done,
  input logic             tick,
  input logic             reseed_done,
  input logic             reseed_req,
  input logic [CNT_W-1:0] use_rld,
  input logic [CNT_W-1:0] age_rld,
  input logic [CNT_W-1:0] use_cnt
);

  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pend <= 1'b0;
    else if (reseed_done) pend <= 1'b0;
    else if (reseed_req)  pend <= 1'b1;
  end

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_req |=> !reseed_req); // R8
  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !reseed_req); // R7
  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_req |-> ($past(gen_done || tick) && !$past(reseed_done))); // R2
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_req |-> ($past(use_rld) != '0 || $past(age_rld) != '0)); // R4
  AST_WRITE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    use_wr |=> use_cnt == $past(use_val)); // R6

endmodule

bind auto_reseed_sched auto_reseed_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .use_wr(use_wr), .use_val(use_val),
  .gen_done(gen_done), .tick(tick), .reseed_done(reseed_done),
  .reseed_req(reseed_req), .use_rld(use_rld), .age_rld(age_rld),
  .use_cnt(use_cnt)
);

// File: tb/auto_reseed_sched_bench.sv
module auto_reseed_sched_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic use_wr = 0, age_wr = 0, gen_done = 0, tick = 0, reseed_done = 0;
  logic [W-1:0] use_val = '0, age_val = '0;
  logic reseed_req;
  logic got;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  auto_reseed_sched #(.CNT_W(W)) u_auto_reseed_sched (
    .clk(clk), .rst_n(rst_n), .use_wr(use_wr), .use_val(use_val),
    .age_wr(age_wr), .age_val(age_val), .gen_done(gen_done), .tick(tick),
    .reseed_done(reseed_done), .reseed_req(reseed_req)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: reseed_req=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic g, input logic t, input logic d);
    @(negedge clk);
    gen_done = g; tick = t; reseed_done = d;
    @(negedge clk);
    gen_done = 0; tick = 0; reseed_done = 0;
    got = reseed_req;
  endtask

  task automatic wr(input logic which_age, input int v);
    @(negedge clk);
    if (which_age) begin age_wr = 1; age_val = W'(v); end
    else begin use_wr = 1; use_val = W'(v); end
    @(negedge clk);
    use_wr = 0; age_wr = 0;
    got = reseed_req;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    check(reseed_req, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reseed_req, 1'b0, "R1 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 0); check(got, 1'b0, "R1 unprogrammed");
    end

    // R2 / R7 / R5 sweep over use-count reloads
    for (int n = 0; n <= 6; n++) begin
      wr(1, 0); wr(0, n);
      for (int i = 1; i <= n + 3; i++) begin
        step(1, 0, 0);
        check(got, (n != 0 && i == n), n == 0 ? "R4 use zero" : (i > n ? "R7 use pending" : "R2 use count"));
      end
      step(0, 0, 1);
      for (int i = 1; i <= n; i++) begin
        step(1, 0, 0); check(got, (i == n), "R5 use reload after done");
      end
      step(0, 0, 1);
    end
    wr(0, 0);

    // R3 / R7 / R5 sweep over age reloads
    for (int n = 0; n <= 6; n++) begin
      wr(1, n);
      for (int i = 1; i <= n + 3; i++) begin
        step(0, 1, 0);
        check(got, (n != 0 && i == n), n == 0 ? "R4 age zero" : (i > n ? "R7 age pending" : "R3 age count"));
      end
      step(0, 0, 1);
      for (int i = 1; i <= n; i++) begin
        step(0, 1, 0); check(got, (i == n), "R5 age reload after done");
      end
      step(0, 0, 1);
    end

    // R8 both expire together
    wr(0, 3); wr(1, 3);
    step(1, 1, 0); check(got, 1'b0, "R8 both 1");
    step(1, 1, 0); check(got, 1'b0, "R8 both 2");
    step(1, 1, 0); check(got, 1'b1, "R8 both fire");
    idle_check("R8 one cycle wide");
    step(1, 1, 0); check(got, 1'b0, "R7 both pending");
    step(0, 0, 1);

    // R6 write mid-count reloads immediately
    wr(1, 0); wr(0, 4);
    step(1, 0, 0); step(1, 0, 0); check(got, 1'b0, "R6 before rewrite");
    wr(0, 2);
    step(1, 0, 0); check(got, 1'b0, "R6 after rewrite 1");
    step(1, 0, 0); check(got, 1'b1, "R6 after rewrite 2");
    step(0, 0, 1);

    // R6 event at same edge as write is discarded
    @(negedge clk); use_wr = 1; use_val = W'(2); gen_done = 1;
    @(negedge clk); use_wr = 0; gen_done = 0;
    step(1, 0, 0); check(got, 1'b0, "R6 same-edge event dropped");
    step(1, 0, 0); check(got, 1'b1, "R6 count from write");
    step(0, 0, 1);

    // R5 host reseed with nothing pending reloads, simultaneous event ignored
    wr(0, 3);
    step(1, 0, 0); step(1, 0, 0);
    step(1, 0, 1); check(got, 1'b0, "R5 host done with event");
    step(1, 0, 0); check(got, 1'b0, "R5 host reload 1");
    step(1, 0, 0); check(got, 1'b0, "R5 host reload 2");
    step(1, 0, 0); check(got, 1'b1, "R5 host reload 3");
    idle_check("R8 pulse ends");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule